// File: doc/BRIEF.md
# Masked priority interrupt controller

This unit sits beside a processor core and holds two software-visible registers: a status word and a cause word. It compares eight live interrupt lines against a per-line enable mask. When the global enable is set and at least one enabled line is active, it requests an exception from the core and reports which line wins. The line with the highest index has the highest priority.

When the core takes the interrupt, it pulses an entry strobe. The unit pushes the current mask onto an internal eight-deep stack. It then narrows the mask so that only lines above the serviced one stay enabled. It leaves the global enable set so that those higher lines can nest, and it writes the external-interrupt code into the cause word. When the core pulses the return strobe, the unit clears the global enable and pops the most recently saved mask. If a ninth nested entry arrives with the stack full, the unit sets a sticky error flag and does not save that mask.

Top module: `irq_ctrl`

## Requirements
- R1: Status word layout: mask in bits 15:8, user-mode bit 4, exception-level bit 1, global enable bit 0. A write with `reg_sel_i`=0 updates all four fields, and every other bit reads 0. Reads are combinational and show writes from the following cycle.
- R2: Cause word layout: bits 15:8 always equal the live `irq_lines_i`, cannot be written, and follow a line change in the same cycle. Exception code is in bits 6:2 and the branch-delay flag is bit 31; both are written with `reg_sel_i`=1. All other bits read 0.
- R3: `exc_req_o` is 1 exactly when the global enable is 1 and (lines AND mask) is nonzero, in the same cycle.
- R4: `irq_id_o` is the highest index set in (lines AND mask) while a request is raised, and 0 otherwise.
- R5: An entry strobe while a request is raised saves the mask and clears mask bits at and below `irq_id_o`. It leaves the global enable at 1 and sets the exception code to 0. All of this is visible on the next cycle.
- R6: A return strobe clears the global enable and restores the most recently saved mask. With nothing saved, the mask is unchanged.
- R7: Up to eight nested entries are undone by returns in last-in, first-out order.
- R8: An entry while eight masks are already saved sets `stack_ovf_o` and does not save the mask, but the mask still narrows. `stack_ovf_o` stays 1 until reset.
- R9: An entry strobe with no request raised is ignored. An accepted entry takes precedence over a return and over a software write in the same cycle. A return takes precedence over a software write.
- R10: After reset, both registers read as if the lines were the only input, every other field is 0, and `stack_ovf_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Software write strobe |
| reg_sel_i | input | 1 | Register select: 0 status, 1 cause |
| reg_wdata_i | input | 32 | Software write data |
| reg_rdata_o | output | 32 | Read data of the selected register |
| irq_lines_i | input | 8 | Interrupt lines, active high |
| exc_req_o | output | 1 | Exception request to the core |
| irq_id_o | output | 3 | Index of the winning line |
| exc_entry_i | input | 1 | Core takes the interrupt |
| exc_return_i | input | 1 | Core returns from the handler |
| stack_ovf_o | output | 1 | Sticky flag for a push into a full stack |

## Verification
A corrupted mask or enable appears at once on `exc_req_o` and `irq_id_o` for suitable line patterns, and on the status read in the same cycle. A wrongly ordered or dropped stack entry stays hidden until the matching return. Its effect then shows on the status mask in the cycle after the return. For this reason the nesting tests unwind every level and compare after each return. The behavioural model uses a queue for the saved masks, so a wrong stack depth or a lost overflow shows as a mismatch on `stack_ovf_o` or on the restored mask.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int unsigned NUM_IRQ = 8;
  localparam int unsigned ID_W    = $clog2(NUM_IRQ);
  localparam int unsigned REG_W   = 32;

  localparam int unsigned ST_MASK_LO = 8;
  localparam int unsigned ST_USER    = 4;
  localparam int unsigned ST_EXL     = 1;
  localparam int unsigned ST_IE      = 0;
  localparam int unsigned CA_PEND_LO = 8;
  localparam int unsigned CA_CODE_LO = 2;
  localparam int unsigned CA_CODE_W  = 5;
  localparam int unsigned CA_BD      = 31;

  localparam logic [CA_CODE_W-1:0] CODE_EXT_IRQ = '0;

  typedef enum logic {SEL_STATUS = 1'b0, SEL_CAUSE = 1'b1} reg_sel_e;
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned N    = 8,
  parameter int unsigned ID_W = $clog2(N)
) (
  input  logic [N-1:0]    cand_i,
  output logic            any_o,
  output logic [ID_W-1:0] id_o
);
  always_comb begin
    id_o = '0;
    for (int i = 0; i < N; i++) begin
      if (cand_i[i]) id_o = ID_W'(i);
    end
  end
  assign any_o = |cand_i;
endmodule

// File: rtl/irq_mask_stack.sv
module irq_mask_stack #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] dout_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic [W-1:0]     mem_q [DEPTH];
  logic [IDX_W-1:0] top_idx, wr_idx;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign top_idx = IDX_W'(cnt_q - 1'b1);
  assign wr_idx  = IDX_W'(cnt_q);
  assign dout_o  = mem_q[top_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (push_i && !full_o) begin
      cnt_q <= cnt_q + 1'b1;
    end else if (pop_i && !empty_o) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[g] <= '0;
      else if (push_i && !full_o && wr_idx == IDX_W'(g)) mem_q[g] <= din_i;
    end
  end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned STACK_DEPTH = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic               reg_sel_i,
  input  logic [REG_W-1:0]   reg_wdata_i,
  output logic [REG_W-1:0]   reg_rdata_o,
  input  logic [NUM_IRQ-1:0] irq_lines_i,
  output logic               exc_req_o,
  output logic [ID_W-1:0]    irq_id_o,
  input  logic               exc_entry_i,
  input  logic               exc_return_i,
  output logic               stack_ovf_o
);
  logic [NUM_IRQ-1:0]   mask_q, mask_narrow, saved_mask;
  logic                 user_q, exl_q, ie_q, bd_q, ovf_q;
  logic [CA_CODE_W-1:0] code_q;
  logic [NUM_IRQ-1:0]   cand;
  logic                 any_cand, take, ret, sw_wr;
  logic                 stk_full, stk_empty;
  logic [ID_W-1:0]      win_id;
  logic                 unused_wdata;

  assign cand = irq_lines_i & mask_q;

  irq_prio_enc #(.N(NUM_IRQ), .ID_W(ID_W)) u_prio (
    .cand_i (cand),
    .any_o  (any_cand),
    .id_o   (win_id)
  );

  assign exc_req_o = ie_q & any_cand;
  assign irq_id_o  = exc_req_o ? win_id : '0;
  assign take      = exc_entry_i & exc_req_o;
  assign ret       = exc_return_i & ~take;
  assign sw_wr     = reg_we_i & ~take & ~ret;

  // keep only lines strictly above the serviced one
  always_comb begin
    for (int i = 0; i < NUM_IRQ; i++) begin
      mask_narrow[i] = mask_q[i] && (i > int'(win_id));
    end
  end

  irq_mask_stack #(.W(NUM_IRQ), .DEPTH(STACK_DEPTH)) u_stack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (take),
    .pop_i   (ret),
    .din_i   (mask_q),
    .dout_o  (saved_mask),
    .full_o  (stk_full),
    .empty_o (stk_empty)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      user_q <= 1'b0;
      exl_q  <= 1'b0;
      ie_q   <= 1'b0;
      code_q <= '0;
      bd_q   <= 1'b0;
      ovf_q  <= 1'b0;
    end else if (take) begin
      mask_q <= mask_narrow;
      ie_q   <= 1'b1;
      code_q <= CODE_EXT_IRQ;
      if (stk_full) ovf_q <= 1'b1;
    end else if (ret) begin
      ie_q <= 1'b0;
      if (!stk_empty) mask_q <= saved_mask;
    end else if (sw_wr) begin
      if (reg_sel_i == SEL_STATUS) begin
        mask_q <= reg_wdata_i[ST_MASK_LO +: NUM_IRQ];
        user_q <= reg_wdata_i[ST_USER];
        exl_q  <= reg_wdata_i[ST_EXL];
        ie_q   <= reg_wdata_i[ST_IE];
      end else begin
        code_q <= reg_wdata_i[CA_CODE_LO +: CA_CODE_W];
        bd_q   <= reg_wdata_i[CA_BD];
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_sel_i == SEL_STATUS) begin
      reg_rdata_o[ST_MASK_LO +: NUM_IRQ] = mask_q;
      reg_rdata_o[ST_USER]               = user_q;
      reg_rdata_o[ST_EXL]                = exl_q;
      reg_rdata_o[ST_IE]                 = ie_q;
    end else begin
      reg_rdata_o[CA_PEND_LO +: NUM_IRQ]  = irq_lines_i;
      reg_rdata_o[CA_CODE_LO +: CA_CODE_W] = code_q;
      reg_rdata_o[CA_BD]                  = bd_q;
    end
  end

  assign stack_ovf_o  = ovf_q;
  assign unused_wdata = ^{reg_wdata_i[30:16], reg_wdata_i[7:5], reg_wdata_i[3:2]};
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
  import irq_ctrl_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_IRQ-1:0] irq_lines_i,
  input logic               exc_req_o,
  input logic [ID_W-1:0]    irq_id_o,
  input logic               exc_entry_i,
  input logic               exc_return_i,
  input logic               stack_ovf_o,
  input logic [NUM_IRQ-1:0] mask_q,
  input logic               ie_q
);
  a_r3_req_needs_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_req_o |-> (irq_lines_i != '0));

  a_r4_id_enabled_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_req_o |-> (irq_lines_i[irq_id_o] && mask_q[irq_id_o]));

  a_r5_entry_keeps_ie: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_entry_i && exc_req_o) |=> ie_q);

  a_r5_mask_only_shrinks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_entry_i && exc_req_o) |=> ((mask_q & ~$past(mask_q)) == '0));

  a_r6_return_clears_ie: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_return_i && !(exc_entry_i && exc_req_o)) |=> !ie_q);

  a_r8_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stack_ovf_o |=> stack_ovf_o);
endmodule

bind irq_ctrl irq_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .irq_lines_i  (irq_lines_i),
  .exc_req_o    (exc_req_o),
  .irq_id_o     (irq_id_o),
  .exc_entry_i  (exc_entry_i),
  .exc_return_i (exc_return_i),
  .stack_ovf_o  (stack_ovf_o),
  .mask_q       (mask_q),
  .ie_q         (ie_q)
);

// File: tb/tb_irq_ctrl.sv
module tb_irq_ctrl;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we = 1'b0, sel = 1'b0, ent = 1'b0, ret = 1'b0;
  logic [31:0] wd = '0;
  logic [7:0]  lines = '0;
  logic [31:0] rdata;
  logic        req, ovf;
  logic [2:0]  id;

  int checks = 0, errors = 0;
  string tag = "R10";

  // reference model state
  logic [7:0] m_mask;
  logic       m_user, m_exl, m_ie, m_bd, m_ovf;
  logic [4:0] m_code;
  logic [7:0] m_stack[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(we), .reg_sel_i(sel),
    .reg_wdata_i(wd), .reg_rdata_o(rdata), .irq_lines_i(lines),
    .exc_req_o(req), .irq_id_o(id), .exc_entry_i(ent),
    .exc_return_i(ret), .stack_ovf_o(ovf)
  );

  function automatic int m_top();
    int t = -1;
    for (int i = 0; i < 8; i++) if (lines[i] && m_mask[i]) t = i;
    return t;
  endfunction

  function automatic logic m_req();
    return m_ie && (m_top() >= 0);
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_mask = '0; m_user = 0; m_exl = 0; m_ie = 0; m_bd = 0; m_ovf = 0; m_code = '0;
      m_stack.delete();
    end else begin
      int t;
      t = m_top();
      if (ent && m_req()) begin
        if (m_stack.size() < 8) m_stack.push_back(m_mask); else m_ovf = 1;
        for (int i = 0; i < 8; i++) if (i <= t) m_mask[i] = 1'b0;
        m_ie = 1; m_code = '0;
      end else if (ret) begin
        m_ie = 0;
        if (m_stack.size() > 0) m_mask = m_stack.pop_back();
      end else if (we) begin
        if (!sel) begin
          m_mask = wd[15:8]; m_user = wd[4]; m_exl = wd[1]; m_ie = wd[0];
        end else begin
          m_code = wd[6:2]; m_bd = wd[31];
        end
      end
    end
  end

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    logic [31:0] e;
    int t;
    t = m_top();
    if (!sel) e = {16'h0, m_mask, 3'b0, m_user, 2'b0, m_exl, m_ie};
    else      e = {m_bd, 15'h0, lines, 1'b0, m_code, 2'b0};
    chk(sel ? "cause R2" : "status R1", rdata, e);
    chk("req R3", 32'(req), 32'(m_req()));
    chk("id R4", 32'(id), m_req() ? 32'(t) : 32'h0);
    chk("ovf R8", 32'(ovf), 32'(m_ovf));
  endtask

  task automatic cyc(logic w, logic s, logic [31:0] d, logic [7:0] l, logic e, logic r);
    @(negedge clk);
    we = w; sel = s; wd = d; lines = l; ent = e; ret = r;
    #1 compare();
  endtask

  task automatic idle(logic s, logic [7:0] l);
    cyc(0, s, '0, l, 0, 0);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (CLK_PERIOD * 200000 / 1ns) #1ns;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 compare();
    rst_ni = 1'b1;
    // R10 reset values on both registers
    idle(0, 8'h00); idle(1, 8'h3C);

    tag = "R1";
    cyc(1, 0, 32'hFFFF_FFFF, 8'h00, 0, 0); idle(0, 8'h00);
    cyc(1, 0, 32'h0000_A512, 8'h00, 0, 0); idle(0, 8'h00);

    tag = "R2";
    cyc(1, 1, 32'hFFFF_FFFF, 8'hA5, 0, 0); idle(1, 8'hA5); idle(1, 8'h5A);
    cyc(1, 1, 32'h0000_0000, 8'h01, 0, 0); idle(1, 8'h80);

    tag = "R3";
    cyc(1, 0, 32'h0000_FF00, 8'hFF, 0, 0); idle(0, 8'hFF); // ie off
    cyc(1, 0, 32'h0000_0001, 8'hFF, 0, 0); idle(0, 8'hFF); // mask zero
    cyc(1, 0, 32'h0000_0F01, 8'hF0, 0, 0); idle(0, 8'hF0); idle(0, 8'h08);

    tag = "R4";
    cyc(1, 0, 32'h0000_5501, 8'hFF, 0, 0);
    idle(0, 8'hFF); idle(0, 8'h15); idle(0, 8'h01); idle(0, 8'h40); idle(0, 8'hAA);

    tag = "R5";
    cyc(1, 0, 32'h0000_FF01, 8'h08, 0, 0);
    cyc(0, 0, '0, 8'h08, 1, 0); idle(0, 8'h08); idle(1, 8'h08);
    idle(0, 8'h10);

    tag = "R6";
    cyc(0, 0, '0, 8'h10, 0, 1); idle(0, 8'h10);
    cyc(0, 0, '0, 8'h00, 0, 1); idle(0, 8'h00);

    tag = "R7";
    cyc(1, 0, 32'h0000_FF01, 8'h00, 0, 0);
    for (int k = 0; k < 8; k++) begin
      cyc(0, 0, '0, 8'(1 << k), 1, 0); idle(0, 8'hFF);
    end
    tag = "R8";
    cyc(1, 0, 32'h0000_F001, 8'h20, 0, 0);
    cyc(0, 0, '0, 8'h20, 1, 0); idle(0, 8'h20); idle(0, 8'hFF);
    tag = "R7";
    for (int k = 0; k < 8; k++) begin
      cyc(0, 0, '0, 8'hFF, 0, 1); idle(0, 8'hFF);
    end
    tag = "R8";
    idle(0, 8'h00);

    tag = "R9";
    cyc(1, 0, 32'h0000_0F01, 8'hF0, 0, 0);
    cyc(0, 0, '0, 8'hF0, 1, 0); idle(0, 8'hF0);           // no request: ignored
    cyc(0, 0, '0, 8'h04, 1, 1); idle(0, 8'h04);           // entry beats return
    cyc(1, 0, 32'h0000_0001, 8'h80, 0, 1); idle(0, 8'h80); // return beats write
    cyc(1, 0, 32'h0000_FF01, 8'h00, 0, 0);
    cyc(1, 0, 32'h0000_0000, 8'h02, 1, 0); idle(0, 8'h02); // entry beats write
    cyc(1, 1, 32'h0000_007C, 8'h02, 0, 0); idle(1, 8'h02);

    tag = "R3";
    for (int n = 0; n < 400; n++) begin
      int r;
      r = $urandom % 16;
      cyc(r == 0, 1'($urandom), $urandom, 8'($urandom), r < 4, r == 5 || r == 6);
    end
    finish_run();
  end
endmodule